// File: doc/BRIEF.md
# DDR2 Power-Down Clock-Enable Controller

This block sits beside the command scheduler of a DDR2 memory controller and owns the clock-enable pin. When the scheduler asks the memory to go quiet, the block first waits until every read burst, write burst and mode-register command has fully drained. It then lowers clock-enable in a cycle where it forces the command bus to NOP/DESELECT. It records whether any bank still held an open row at that moment. If one did, the memory is in active power-down. If all banks were idle, it is in precharge power-down.

While the memory is asleep, the block keeps clock-enable low for at least a programmed minimum number of cycles. A wake request, a refresh that falls due, or an expiring residency limit brings it back. A wake or refresh that arrives too early is remembered and served as soon as the minimum has passed. On exit, clock-enable rises together with a forced NOP, and a busy output keeps the scheduler quiet until the exit delay has expired.

All cycle counts are taken from configuration inputs while reset is held. They are constant afterwards.

Top module: `pd_cke_ctrl`

## Requirements
- R1: After reset, `cke` is 1, `busy` is 0, `force_nop` is 0 and `pd_mode` is 0 (none).
- R2: With `pd_req` high, no burst or mode-register wait outstanding, no command and no `ref_due` in a cycle, `cke` is 0 in the next cycle. `busy` and `force_nop` are 1 in every cycle where `cke` is 0.
- R3: A read issued in cycle c keeps `cke` at 1 through cycle c+RD+1, where RD is `cfg_rd_done`. With `pd_req` held, `cke` is first 0 in cycle c+RD+2.
- R4: A write issued in cycle c keeps `cke` at 1 through cycle c+W+1, where W = `cfg_wr_post` + max(`cfg_wr_rec`, `cfg_wtr`).
- R5: A mode-register command issued in cycle c keeps `cke` at 1 through cycle c+`cfg_mrd`+1.
- R6: While `cke` is 0, `pd_mode` shows the bank state sampled in the entry cycle: 1 for precharge power-down (`bank_open` all zero) or 2 for active power-down (any bit set). While `cke` is 1, `pd_mode` is 0.
- R7: Every low period of `cke` lasts at least T = max(`cfg_tcke`, 1) cycles. A wake or refresh request that arrives earlier is held and served in the cycle the minimum is met.
- R8: A wake request in an eligible power-down cycle j makes `cke` 1 in cycle j+1. `force_nop` is 1 in cycle j+1 only. `busy` stays 1 for max(`cfg_xp`, T) cycles starting at j+1.
- R9: `ref_due` high blocks entry in that cycle. During power-down, `ref_due` forces an exit exactly as a wake request does.
- R10: Power-down entered with `cke` first 0 in cycle e ends with `cke` 1 no later than cycle e+`cfg_max_res`, even without any wake request.
- R11: `wake_req` has no effect while `cke` is 1. `pd_req` has no effect while `busy` is 1 after an exit; entry follows in the first cycle with `busy` at 0.
- R12: A read, write or mode-register command in the same cycle as an otherwise valid entry cancels that entry: `cke` stays 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| pd_req | input | 1 | Scheduler asks for power-down |
| wake_req | input | 1 | Scheduler asks to leave power-down |
| ref_due | input | 1 | A refresh must be issued soon |
| cmd_rd | input | 1 | A read is issued this cycle |
| cmd_wr | input | 1 | A write is issued this cycle |
| cmd_mrs | input | 1 | A mode or extended mode register command is issued this cycle |
| bank_open | input | NB | One bit per bank, set while that bank holds an open row |
| cfg_rd_done | input | CW | Cycles from read issue until its postamble has passed |
| cfg_wr_post | input | CW | Cycles from write issue until its postamble has passed |
| cfg_wr_rec | input | CW | Write recovery cycles after the postamble |
| cfg_wtr | input | CW | Write-to-read cycles after the postamble |
| cfg_mrd | input | CW | Mode-register command time in cycles |
| cfg_tcke | input | CW | Minimum cycles per clock-enable level |
| cfg_xp | input | CW | Exit-to-first-command delay in cycles |
| cfg_max_res | input | RW | Maximum power-down residency in cycles |
| cke | output | 1 | Clock-enable to the memory |
| force_nop | output | 1 | Command bus must carry NOP/DESELECT |
| busy | output | 1 | Scheduler must issue no valid command |
| pd_mode | output | 2 | 0 none, 1 precharge power-down, 2 active power-down |

## Verification
Entry can coincide with a new read, or with a refresh falling due. The bench raises `pd_req` in the same cycle as `cmd_rd` while every wait counter is already zero. It expects the read to win: `cke` stays high for the full read drain and drops exactly one cycle after it. The refresh case is provoked in two ways. `ref_due` is held over cycles where entry would otherwise fire, which must keep `cke` high. `ref_due` is also raised inside the minimum low window, which must produce an exit in exactly the cycle the minimum expires.

// File: rtl/pd_cke_ctrl.sv
module pd_cke_ctrl #(
  parameter int NB = 8,
  parameter int CW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_req,
  input  logic          wake_req,
  input  logic          ref_due,
  input  logic          cmd_rd,
  input  logic          cmd_wr,
  input  logic          cmd_mrs,
  input  logic [NB-1:0] bank_open,
  input  logic [CW-1:0] cfg_rd_done,
  input  logic [CW-1:0] cfg_wr_post,
  input  logic [CW-1:0] cfg_wr_rec,
  input  logic [CW-1:0] cfg_wtr,
  input  logic [CW-1:0] cfg_mrd,
  input  logic [CW-1:0] cfg_tcke,
  input  logic [CW-1:0] cfg_xp,
  input  logic [RW-1:0] cfg_max_res,
  output logic          cke,
  output logic          force_nop,
  output logic          busy,
  output logic [1:0]    pd_mode
);
  localparam int WW = CW + 1;
  localparam logic [1:0] MODE_NONE = 2'd0;
  localparam logic [1:0] MODE_PRE  = 2'd1;
  localparam logic [1:0] MODE_ACT  = 2'd2;

  typedef enum logic [1:0] {S_RUN, S_DOWN, S_WAKE} state_t;

  state_t        state;
  logic [CW-1:0] rd_len, mr_len, tcke_len, wake_len;
  logic [WW-1:0] wr_len;
  logic [RW-1:0] res_lim;
  logic [CW-1:0] rd_cnt, mr_cnt, tc_cnt, wk_cnt;
  logic [WW-1:0] wr_cnt;
  logic [RW-1:0] res_cnt;
  logic          cke_q, edge_nop, wake_pend;
  logic [1:0]    mode_q;

  logic [CW-1:0] tcke_in, rec_in;
  logic          quiet, enter, want_out, leave;

  assign tcke_in = (cfg_tcke == '0) ? CW'(1) : cfg_tcke;
  assign rec_in  = (cfg_wr_rec > cfg_wtr) ? cfg_wr_rec : cfg_wtr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_len   <= cfg_rd_done;
      wr_len   <= WW'(cfg_wr_post) + WW'(rec_in);
      mr_len   <= cfg_mrd;
      tcke_len <= tcke_in;
      wake_len <= (cfg_xp > tcke_in) ? cfg_xp : tcke_in;
      res_lim  <= cfg_max_res;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
      mr_cnt <= '0;
    end else begin
      rd_cnt <= cmd_rd  ? rd_len : ((rd_cnt != '0) ? rd_cnt - 1'b1 : '0);
      wr_cnt <= cmd_wr  ? wr_len : ((wr_cnt != '0) ? wr_cnt - 1'b1 : '0);
      mr_cnt <= cmd_mrs ? mr_len : ((mr_cnt != '0) ? mr_cnt - 1'b1 : '0);
    end
  end

  assign quiet    = (rd_cnt == '0) && (wr_cnt == '0) && (mr_cnt == '0) &&
                    !(cmd_rd || cmd_wr || cmd_mrs);
  assign enter    = (state == S_RUN) && pd_req && quiet && !ref_due;
  assign want_out = wake_pend || wake_req || ref_due || (res_cnt >= res_lim);
  assign leave    = (state == S_DOWN) && want_out && (tc_cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_RUN;
      cke_q     <= 1'b1;
      edge_nop  <= 1'b0;
      wake_pend <= 1'b0;
      mode_q    <= MODE_NONE;
      tc_cnt    <= '0;
      wk_cnt    <= '0;
      res_cnt   <= '0;
    end else begin
      edge_nop <= leave;
      case (state)
        S_RUN: begin
          if (enter) begin
            state     <= S_DOWN;
            cke_q     <= 1'b0;
            tc_cnt    <= tcke_len;
            res_cnt   <= RW'(1);
            wake_pend <= 1'b0;
            mode_q    <= (|bank_open) ? MODE_ACT : MODE_PRE;
          end
        end
        S_DOWN: begin
          if (tc_cnt > CW'(1)) tc_cnt <= tc_cnt - 1'b1;
          if (res_cnt != '1) res_cnt <= res_cnt + 1'b1;
          if (leave) begin
            state     <= S_WAKE;
            cke_q     <= 1'b1;
            wk_cnt    <= wake_len;
            wake_pend <= 1'b0;
            mode_q    <= MODE_NONE;
          end else if (wake_req || ref_due) begin
            wake_pend <= 1'b1;
          end
        end
        S_WAKE: begin
          if (wk_cnt <= CW'(1)) state <= S_RUN;
          else wk_cnt <= wk_cnt - 1'b1;
        end
        default: state <= S_RUN;
      endcase
    end
  end

  assign cke       = cke_q;
  assign busy      = (state != S_RUN);
  assign force_nop = (state == S_DOWN) || edge_nop;
  assign pd_mode   = mode_q;
endmodule

module pd_cke_ctrl_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke,
  input logic          force_nop,
  input logic          busy,
  input logic [1:0]    pd_mode,
  input logic          cmd_rd,
  input logic          cmd_wr,
  input logic          cmd_mrs,
  input logic          ref_due,
  input logic [CW-1:0] tcke_len
);
  logic [CW:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (cke) low_run <= '0;
    else if (low_run != '1) low_run <= low_run + 1'b1;
  end

  p_nop_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cke != $past(cke)) |-> force_nop);

  p_busy_while_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> busy);

  p_cmd_keeps_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && (cmd_rd || cmd_wr || cmd_mrs)) |=> cke);

  p_mode_high_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> (pd_mode == 2'd0));

  p_mode_low_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (pd_mode == 2'd1 || pd_mode == 2'd2));

  p_min_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (low_run >= (CW+1)'(tcke_len)));

  p_ref_blocks_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && ref_due) |=> cke);
endmodule

bind pd_cke_ctrl pd_cke_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .force_nop(force_nop), .busy(busy),
  .pd_mode(pd_mode), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_mrs(cmd_mrs),
  .ref_due(ref_due), .tcke_len(tcke_len)
);

// File: tb/pd_cke_ctrl_bench.sv
`timescale 1ns/100ps
module pd_cke_ctrl_bench;
  localparam int NB = 8;
  localparam int CW = 8;
  localparam int RW = 16;

  localparam int RD = 5, WP = 2, WRC = 6, WTR = 3, MRD = 4, TCKE = 3, XP = 4, MAXRES = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 0, wake_req = 0, ref_due = 0, cmd_rd = 0, cmd_wr = 0, cmd_mrs = 0;
  logic [NB-1:0] bank_open = '0;
  logic cke, force_nop, busy;
  logic [1:0] pd_mode;

  always #2.5 clk = ~clk;

  pd_cke_ctrl #(.NB(NB), .CW(CW), .RW(RW)) u_pd_cke_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_req(wake_req), .ref_due(ref_due),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_mrs(cmd_mrs), .bank_open(bank_open),
    .cfg_rd_done(CW'(RD)), .cfg_wr_post(CW'(WP)), .cfg_wr_rec(CW'(WRC)), .cfg_wtr(CW'(WTR)),
    .cfg_mrd(CW'(MRD)), .cfg_tcke(CW'(TCKE)), .cfg_xp(CW'(XP)), .cfg_max_res(RW'(MAXRES)),
    .cke(cke), .force_nop(force_nop), .busy(busy), .pd_mode(pd_mode)
  );

  typedef struct {
    int         cyc;
    logic       k;
    logic       b;
    logic       n;
    logic [1:0] m;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int base = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic want(input int off, input logic k, input logic b, input logic n,
                      input logic [1:0] m, input string tag);
    exp_t e;
    int idx;
    e.cyc = base + off; e.k = k; e.b = b; e.n = n; e.m = m; e.tag = tag;
    idx = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > e.cyc) begin idx = i; break; end
    end
    q.insert(idx, e);
  endtask

  task automatic span(input int lo, input int hi, input logic k, input logic b,
                      input logic n, input logic [1:0] m, input string tag);
    for (int o = lo; o <= hi; o++) want(o, k, b, n, m, tag);
  endtask

  task automatic mark();
    @(negedge clk);
    base = cyc;
  endtask

  task automatic at(input int off);
    while (cyc < base + off) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      checks++;
      if (q[0].cyc != cyc) begin
        errors++;
        $display("FAIL %s cycle %0d missed (actual cycle %0d expected %0d)", q[0].tag, q[0].cyc, cyc, q[0].cyc);
      end else if (cke !== q[0].k || busy !== q[0].b || force_nop !== q[0].n || pd_mode !== q[0].m) begin
        errors++;
        $display("FAIL %s cycle %0d actual cke=%b busy=%b nop=%b mode=%0d expected cke=%b busy=%b nop=%b mode=%0d",
                 q[0].tag, cyc, cke, busy, force_nop, pd_mode, q[0].k, q[0].b, q[0].n, q[0].m);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mark();
    span(1, 2, 1, 0, 0, 2'd0, "R1");
    at(3);

    // R2 / R6 precharge entry, R8 exit timing
    mark();
    pd_req = 1; bank_open = '0;
    want(1, 0, 1, 1, 2'd1, "R2");
    span(2, 6, 0, 1, 1, 2'd1, "R6");
    want(7, 1, 1, 1, 2'd0, "R8");
    span(8, 10, 1, 1, 0, 2'd0, "R8");
    want(11, 1, 0, 0, 2'd0, "R8");
    at(1); pd_req = 0;
    at(6); wake_req = 1;
    at(7); wake_req = 0;
    at(12);

    // R6 active mode, R7 early wake held pending
    mark();
    pd_req = 1; bank_open = 8'h04;
    want(1, 0, 1, 1, 2'd2, "R6");
    span(2, 3, 0, 1, 1, 2'd2, "R7");
    want(4, 1, 1, 1, 2'd0, "R7");
    want(7, 1, 1, 0, 2'd0, "R7");
    want(8, 1, 0, 0, 2'd0, "R7");
    at(1); pd_req = 0;
    at(2); wake_req = 1;
    at(3); wake_req = 0;
    at(9);

    // R12 read in entry cycle, R3 read drain
    mark();
    bank_open = '0; cmd_rd = 1; pd_req = 1;
    want(1, 1, 0, 0, 2'd0, "R12");
    span(2, RD + 1, 1, 0, 0, 2'd0, "R3");
    want(RD + 2, 0, 1, 1, 2'd1, "R3");
    want(11, 1, 1, 1, 2'd0, "R8");
    want(15, 1, 0, 0, 2'd0, "R8");
    at(1); cmd_rd = 0;
    at(7); pd_req = 0;
    at(10); wake_req = 1;
    at(11); wake_req = 0;
    at(16);

    // R4 write drain
    mark();
    cmd_wr = 1; pd_req = 1;
    span(1, WP + WRC + 1, 1, 0, 0, 2'd0, "R4");
    want(WP + WRC + 2, 0, 1, 1, 2'd1, "R4");
    want(14, 1, 1, 1, 2'd0, "R4");
    want(18, 1, 0, 0, 2'd0, "R4");
    at(1); cmd_wr = 0;
    at(10); pd_req = 0;
    at(13); wake_req = 1;
    at(14); wake_req = 0;
    at(19);

    // R5 mode-register command time
    mark();
    cmd_mrs = 1; pd_req = 1;
    span(1, MRD + 1, 1, 0, 0, 2'd0, "R5");
    want(MRD + 2, 0, 1, 1, 2'd1, "R5");
    want(10, 1, 1, 1, 2'd0, "R5");
    want(14, 1, 0, 0, 2'd0, "R5");
    at(1); cmd_mrs = 0;
    at(6); pd_req = 0;
    at(9); wake_req = 1;
    at(10); wake_req = 0;
    at(15);

    // R9 refresh blocks entry and forces exit
    mark();
    ref_due = 1; pd_req = 1;
    span(1, 4, 1, 0, 0, 2'd0, "R9");
    want(5, 0, 1, 1, 2'd1, "R9");
    want(7, 0, 1, 1, 2'd1, "R9");
    want(8, 1, 1, 1, 2'd0, "R9");
    want(12, 1, 0, 0, 2'd0, "R9");
    at(4); ref_due = 0;
    at(5); pd_req = 0;
    at(6); ref_due = 1;
    at(8); ref_due = 0;
    at(13);

    // R10 residency limit, R11 pd_req during exit window
    mark();
    pd_req = 1;
    want(1, 0, 1, 1, 2'd1, "R10");
    want(MAXRES, 0, 1, 1, 2'd1, "R10");
    want(MAXRES + 1, 1, 1, 1, 2'd0, "R10");
    want(24, 1, 1, 0, 2'd0, "R11");
    want(25, 1, 0, 0, 2'd0, "R11");
    want(26, 0, 1, 1, 2'd1, "R11");
    want(29, 1, 1, 1, 2'd0, "R7");
    want(33, 1, 0, 0, 2'd0, "R8");
    at(1); pd_req = 0;
    at(22); pd_req = 1;
    at(26); pd_req = 0;
    at(27); wake_req = 1;
    at(28); wake_req = 0;
    at(34);

    // R11 wake while awake ignored
    mark();
    wake_req = 1;
    span(1, 5, 1, 0, 0, 2'd0, "R11");
    at(4); wake_req = 0;
    at(7);

    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 pending expectations actual %0d expected 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule